// File: doc/BRIEF.md
# Microcontroller Interrupt Sequencing Unit

This unit sits beside the fetch and execute logic of a small microcontroller core that has a single interrupt vector. It holds one flag bit per interrupt source, a per-source enable, an enable for the peripheral group of sources and a master enable. It decides at instruction-cycle boundaries whether execution must be redirected to the vector.

When it redirects, it asks the core for a vector load. On the acknowledging cycle it tells the core to drop the prefetched instruction, to push the current program counter onto the return stack and to load the vector address. In the same cycle it clears the master enable.

When the core decodes a return-from-interrupt, the unit pops the return stack, steers the popped address into the program counter and sets the master enable again. Flags are never cleared by hardware. Software clears them through the register port.

The redirect request follows a valid/ready rule. `redirect_valid` rises after a cycle boundary and stays high, with nothing about the request changing, until the core raises `redirect_ready`. The cycle in which both are high is the only cycle that flushes, pushes and loads the vector. The core may hold `redirect_ready` low for any number of cycles. All other pins are plain control or status pins.

Top module: `irq_sequencer`

## Requirements
- R1: After reset, registers 0, 1 and 2 read as zero and `redirect_valid` is low. Register 0 is the control register. Register 1 holds the per-source enables. Register 2 holds the flags.
- R2: A source event sets that source's flag in register 2 (bit i for source i) even when the master, group and source enables are clear. For a synchronous source, the flag is visible after the first clock edge that samples the event high.
- R3: Sources 0 to N_CORE-1 form the core group. They can cause a dispatch when their own enable bit and the master enable are set. The remaining sources form the peripheral group, and they also need the group enable (control bit 1).
- R4: A clock edge with `cyc_strobe` high, the master enable set, no request outstanding and an enabled flagged source raises `redirect_valid` after that edge. The request stays high until a cycle with `redirect_ready` high.
- R5: In the cycle where `redirect_valid` and `redirect_ready` are both high, `flush_o`, `push_en` and `pc_load_en` are high, `push_data` equals `pc_in` and `pc_load_addr` equals the vector 0x004. The master enable reads 0 afterwards.
- R6: While the master enable (control bit 0) is clear, events still set flags and `redirect_valid` stays low. A flag that is still pending when the master enable is set again causes a dispatch at the next strobe.
- R7: With `ret_req` high and no vector-load handshake in the same cycle, `pop_en` and `pc_load_en` are high and `pc_load_addr` equals `pop_data`. The master enable reads 1 afterwards.
- R8: A dispatch leaves the flags unchanged. A flag that is not cleared before return causes a dispatch again at the first strobe after return.
- R9: Sources marked in ASYNC_MASK pass through two synchronizer flops and a rising-edge detector. The flag sets on the third clock edge after the input rises. A level that is held high does not set the flag again after software has cleared it.
- R10: A write to register 2 loads the flags from the write data, where 1 sets a flag and 0 clears it. A hardware event in the same cycle wins over a software clear.
- R11: In register 0, bit 0 is the master enable and bit 1 is the group enable. Unused bits and register address 3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW | Register select |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| evt_i | input | N_SRC | Source event inputs |
| cyc_strobe | input | 1 | Instruction-cycle boundary from the core |
| pc_in | input | PC_W | Current program counter |
| redirect_valid | output | 1 | Vector-load request |
| redirect_ready | input | 1 | Core accepts the vector load |
| flush_o | output | 1 | Discard the prefetched instruction |
| push_en | output | 1 | Push `push_data` onto the return stack |
| push_data | output | PC_W | Address to push |
| pc_load_en | output | 1 | Load the program counter |
| pc_load_addr | output | PC_W | Program counter load value |
| ret_req | input | 1 | Return-from-interrupt decoded |
| pop_en | output | 1 | Pop the return stack |
| pop_data | input | PC_W | Top-of-stack address |

## Verification
The hardest situation to reach is a re-dispatch driven only by a stale flag. This needs a dispatch, then a return with the flag still set, then another strobe, while the core keeps the request waiting. The stimulus holds `redirect_ready` low for several cycles and then leaves a flag uncleared across a return. It also drives a software clear of the flags in the same cycle as a source event, and it holds an asynchronous input high across a software clear. A behavioural model compares every output on every clock.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_EN   = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_FLAG = 2'd2;
  localparam int CTRL_MASTER = 0;
  localparam int CTRL_GROUP  = 1;
endpackage

// File: rtl/irq_event_capture.sv
module irq_event_capture #(
  parameter int N_SRC = 6,
  parameter logic [N_SRC-1:0] ASYNC_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt_i,
  output logic [N_SRC-1:0] set_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (ASYNC_MASK[i]) begin : g_async
      logic [2:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[1:0], evt_i[i]};
      end
      assign set_o[i] = sh_q[1] & ~sh_q[2];
      // R9: a held level yields one set pulse only
      assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_o[i] |=> !set_o[i]);
    end else begin : g_sync
      assign set_o[i] = evt_i[i];
    end
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_seq_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int N_CORE = 3,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [N_SRC-1:0]  set_i,
  input  logic              hw_master_clr,
  input  logic              hw_master_set,
  output logic              master_en,
  output logic              pending
);
  localparam int PADW = DW - N_SRC;

  logic             master_q, group_q;
  logic [N_SRC-1:0] en_q, flag_q, flag_base, grp_ok;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[DW-1:N_SRC];

  always_comb begin
    flag_base = flag_q;
    if (we && addr == ADDR_FLAG) flag_base = wdata[N_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      group_q  <= 1'b0;
      en_q     <= '0;
      flag_q   <= '0;
    end else begin
      if (we && addr == ADDR_CTRL) begin
        master_q <= wdata[CTRL_MASTER];
        group_q  <= wdata[CTRL_GROUP];
      end
      if (hw_master_set) master_q <= 1'b1;
      if (hw_master_clr) master_q <= 1'b0;
      if (we && addr == ADDR_EN) en_q <= wdata[N_SRC-1:0];
      flag_q <= flag_base | set_i;
    end
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_grp
    if (i < N_CORE) begin : g_core
      assign grp_ok[i] = 1'b1;
    end else begin : g_peri
      assign grp_ok[i] = group_q;
    end
  end

  assign pending   = |(flag_q & en_q & grp_ok);
  assign master_en = master_q;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: begin
        rdata[CTRL_MASTER] = master_q;
        rdata[CTRL_GROUP]  = group_q;
      end
      ADDR_EN:   rdata = {{PADW{1'b0}}, en_q};
      ADDR_FLAG: rdata = {{PADW{1'b0}}, flag_q};
      default:   rdata = '0;
    endcase
  end

  // R2 / R10: an event always leaves its flag set
  assert_evt_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((flag_q & $past(set_i)) == $past(set_i)));
  // R5: vector handshake clears the master enable
  assert_master_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hw_master_clr |=> !master_q);
  // R7: return sets the master enable
  assert_master_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_master_set && !hw_master_clr) |=> master_q);
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch #(
  parameter int PC_W   = 9,
  parameter int VECTOR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_strobe,
  input  logic            master_en,
  input  logic            pending,
  output logic            redirect_valid,
  input  logic            redirect_ready,
  input  logic [PC_W-1:0] pc_in,
  input  logic            ret_req,
  input  logic [PC_W-1:0] pop_data,
  output logic            flush_o,
  output logic            push_en,
  output logic [PC_W-1:0] push_data,
  output logic            pc_load_en,
  output logic [PC_W-1:0] pc_load_addr,
  output logic            pop_en,
  output logic            hw_master_clr,
  output logic            hw_master_set
);
  localparam logic [PC_W-1:0] VEC = PC_W'(VECTOR);

  logic busy_q, fire;

  assign fire = busy_q & redirect_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                             busy_q <= 1'b0;
    else if (fire)                                          busy_q <= 1'b0;
    else if (!busy_q && cyc_strobe && master_en && pending) busy_q <= 1'b1;
  end

  assign redirect_valid = busy_q;
  assign flush_o        = fire;
  assign push_en        = fire;
  assign push_data      = pc_in;
  assign pop_en         = ret_req & ~fire;
  assign pc_load_en     = fire | ret_req;
  assign pc_load_addr   = fire ? VEC : pop_data;
  assign hw_master_clr  = fire;
  assign hw_master_set  = ret_req & ~fire;

  // R4: request held until accepted
  assert_valid_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && !redirect_ready) |=> redirect_valid);
  // R6: a request only starts from a strobe with master enable and pending source
  assert_gated_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(redirect_valid) |-> $past(cyc_strobe && master_en && pending));
  // R5: request drops right after the handshake
  assert_drop_after_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_valid && redirect_ready) |=> !redirect_valid);
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_seq_pkg::*;
#(
  parameter int N_SRC  = 6,
  parameter int N_CORE = 3,
  parameter logic [N_SRC-1:0] ASYNC_MASK = 6'b100010,
  parameter int DW     = 8,
  parameter int AW     = REG_AW,
  parameter int PC_W   = 9,
  parameter int VECTOR = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             cyc_strobe,
  input  logic [PC_W-1:0]  pc_in,
  output logic             redirect_valid,
  input  logic             redirect_ready,
  output logic             flush_o,
  output logic             push_en,
  output logic [PC_W-1:0]  push_data,
  output logic             pc_load_en,
  output logic [PC_W-1:0]  pc_load_addr,
  input  logic             ret_req,
  output logic             pop_en,
  input  logic [PC_W-1:0]  pop_data
);
  logic [N_SRC-1:0] set_w;
  logic             master_w, pending_w, mclr_w, mset_w;

  irq_event_capture #(.N_SRC(N_SRC), .ASYNC_MASK(ASYNC_MASK)) u_cap (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .set_o(set_w));

  irq_flag_bank #(.N_SRC(N_SRC), .N_CORE(N_CORE), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .set_i(set_w), .hw_master_clr(mclr_w),
    .hw_master_set(mset_w), .master_en(master_w), .pending(pending_w));

  irq_dispatch #(.PC_W(PC_W), .VECTOR(VECTOR)) u_disp (
    .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .master_en(master_w),
    .pending(pending_w), .redirect_valid(redirect_valid),
    .redirect_ready(redirect_ready), .pc_in(pc_in), .ret_req(ret_req),
    .pop_data(pop_data), .flush_o(flush_o), .push_en(push_en),
    .push_data(push_data), .pc_load_en(pc_load_en), .pc_load_addr(pc_load_addr),
    .pop_en(pop_en), .hw_master_clr(mclr_w), .hw_master_set(mset_w));
endmodule

// File: tb/irq_sequencer_bench.sv
module irq_sequencer_bench;
  logic       clk = 0, rst_n = 0;
  logic       reg_we = 0, cyc_strobe = 0, redirect_ready = 0, ret_req = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [5:0] evt_i = 0;
  logic [8:0] pc_in = 0, pop_data = 0, push_data, pc_load_addr;
  logic       redirect_valid, flush_o, push_en, pc_load_en, pop_en;
  int checks = 0, errors = 0;
  bit done = 0;

  localparam logic [5:0] ASYNC = 6'b100010;

  // behavioural reference state
  bit       m_master, m_group, m_busy;
  bit [5:0] m_en, m_flag, m_a1, m_a2, m_a3;

  always #5 clk = ~clk;

  irq_sequencer u_irq_sequencer (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_pending();
    bit [5:0] ok = {m_group, m_group, m_group, 3'b111};
    return |(m_flag & m_en & ok);
  endfunction

  function automatic logic [7:0] m_rdata();
    case (reg_addr)
      2'd0: return {6'b0, m_group, m_master};
      2'd1: return {2'b0, m_en};
      2'd2: return {2'b0, m_flag};
      default: return 8'h00;
    endcase
  endfunction

  task automatic compare_all();
    bit fire = m_busy & redirect_ready;
    chk("R4 redirect_valid", redirect_valid, m_busy);
    chk("R5 flush_o", flush_o, fire);
    chk("R5 push_en", push_en, fire);
    chk("R5 push_data", push_data, pc_in);
    chk("R7 pop_en", pop_en, ret_req & ~fire);
    chk("R7 pc_load_en", pc_load_en, fire | ret_req);
    chk("R7 pc_load_addr", pc_load_addr, fire ? 9'h004 : pop_data);
    chk("R11 reg_rdata", reg_rdata, m_rdata());
  endtask

  task automatic step();
    bit fire;
    bit [5:0] set, nf;
    bit nm, ng, nb;
    #1 compare_all();
    fire = m_busy & redirect_ready;
    set  = (ASYNC & m_a2 & ~m_a3) | (~ASYNC & evt_i);
    nf   = ((reg_we && reg_addr == 2) ? reg_wdata[5:0] : m_flag) | set;
    nm   = (reg_we && reg_addr == 0) ? reg_wdata[0] : m_master;
    ng   = (reg_we && reg_addr == 0) ? reg_wdata[1] : m_group;
    if (ret_req && !fire) nm = 1;
    if (fire) nm = 0;
    nb = fire ? 0 : (m_busy ? 1 : (cyc_strobe && m_master && m_pending()));
    @(posedge clk);
    if (reg_we && reg_addr == 1) m_en = reg_wdata[5:0];
    m_a3 = m_a2; m_a2 = m_a1; m_a1 = evt_i;
    m_flag = nf; m_master = nm; m_group = ng; m_busy = nb;
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d; step(); reg_we = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    reg_addr = a; #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse_evt(int s);
    evt_i[s] = 1; step(); evt_i[s] = 0;
  endtask

  task automatic strobe();
    cyc_strobe = 1; step(); cyc_strobe = 0;
  endtask

  task automatic do_ret(logic [8:0] a);
    ret_req = 1; pop_data = a; #1;
    chk("R7 pop address", pc_load_addr, a);
    chk("R7 pop_en", pop_en, 1'b1);
    step(); ret_req = 0;
  endtask

  task automatic accept(logic [8:0] pc);
    redirect_ready = 1; pc_in = pc; #1;
    chk("R5 vector", pc_load_addr, 9'h004);
    chk("R5 pushed pc", push_data, pc);
    chk("R5 flush", flush_o, 1'b1);
    step(); redirect_ready = 0;
  endtask

  initial begin
    @(negedge clk); step(); step();
    rst_n = 1;
    rd(0, 8'h00, "R1 ctrl"); rd(1, 8'h00, "R1 en"); rd(2, 8'h00, "R1 flag");
    chk("R1 valid", redirect_valid, 1'b0);
    step();
    // R2: flag sets with every enable clear
    pulse_evt(0); step();
    rd(2, 8'h01, "R2 flag set while disabled");
    chk("R2 no redirect", redirect_valid, 1'b0);
    // R4/R5: dispatch and held request
    wr(1, 8'h01); wr(0, 8'h01);
    step(); chk("R4 no request before strobe", redirect_valid, 1'b0);
    strobe();
    for (int k = 0; k < 3; k++) begin
      chk("R4 request held", redirect_valid, 1'b1); step();
    end
    accept(9'h0A5);
    rd(0, 8'h00, "R5 master cleared");
    chk("R5 request dropped", redirect_valid, 1'b0);
    // R6: master clear blocks dispatch, flags still set
    wr(1, 8'h05); pulse_evt(2); strobe();
    chk("R6 no redirect while master clear", redirect_valid, 1'b0);
    rd(2, 8'h05, "R6 flag recorded");
    do_ret(9'h123);
    rd(0, 8'h01, "R7 master set by return");
    // R8: stale flags redispatch
    strobe();
    chk("R8 redispatch from uncleared flag", redirect_valid, 1'b1);
    accept(9'h124);
    rd(2, 8'h05, "R8 flags kept by dispatch");
    wr(2, 8'h00); do_ret(9'h124);
    strobe(); chk("R8 no dispatch after clear", redirect_valid, 1'b0);
    // R3: peripheral group needs group enable
    wr(1, 8'h08); pulse_evt(3); strobe();
    chk("R3 peripheral blocked by group enable", redirect_valid, 1'b0);
    wr(0, 8'h03); strobe();
    chk("R3 peripheral dispatch with group enable", redirect_valid, 1'b1);
    accept(9'h033); wr(2, 8'h00); do_ret(9'h033);
    pulse_evt(2); strobe();
    chk("R3 core source blocked by own enable", redirect_valid, 1'b0);
    wr(2, 8'h00);
    // R9: async source timing
    evt_i[1] = 1; step(); step();
    rd(2, 8'h00, "R9 not yet after two edges");
    step(); rd(2, 8'h02, "R9 set on third edge");
    wr(2, 8'h00); step(); step(); step();
    rd(2, 8'h00, "R9 held level does not reset flag");
    evt_i[1] = 0; step(); step(); step();
    // R10: event wins over software clear, software set
    reg_we = 1; reg_addr = 2; reg_wdata = 8'h00; evt_i[4] = 1; step();
    reg_we = 0; evt_i[4] = 0;
    rd(2, 8'h10, "R10 event beats clear");
    wr(2, 8'h20); rd(2, 8'h20, "R10 software set");
    rd(3, 8'h00, "R11 unused address");
    rd(0, 8'h03, "R11 control bits");
    step(); step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule